// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Cluster

This block keeps a set of small per-core caches coherent over one shared, single-cycle bus. Each core has a direct-mapped cache with one data word per line and its own controller. Every line is Invalid, Shared or Modified. A controller serves hits locally. It sends misses, ownership upgrades and dirty evictions onto the bus. It watches every transaction that other controllers put on the bus.

A round-robin arbiter grants the bus to one controller per cycle. Because only one transaction happens per cycle, conflicting writes to one address take effect one after the other, and every core then sees the same final value. A controller that sees an invalidate for a line it holds drops that line. When another core misses on a line that a controller holds Modified, that owner supplies the word instead of memory, writes it back to the shared store in the same bus cycle, and downgrades its own copy to Shared. The shared store is an array of words. After reset, the word at address `a` is `a XOR 0x5A`.

Each core uses a level handshake. It raises `core_req` with the operation and holds it until `core_done` pulses, and it lowers the request in that same cycle. `core_rdata` carries the read word, or for a write the word just written. The bus outputs show the transaction of the current cycle.

Top module: `snoop_cluster`

## Requirements
- R1: After reset every line is Invalid, no `core_done` is high, and `bus_op` is 0 (idle), so the first access to any address goes to the bus.
- R2: A read that hits a Shared or Modified line completes with `core_done` in the cycle after the request is first seen, with no bus transaction.
- R3: A read miss puts a read on the bus (`bus_op` = 1), installs the line as Shared and completes one cycle after its grant. When no cache owns the line, it returns the word from the shared store.
- R4: A write to a line that is not Modified broadcasts an invalidate (`bus_op` = 2) and completes one cycle after its grant with the line Modified. A write to a Modified line completes locally in one cycle with no bus transaction.
- R5: A controller that observes another core's invalidate for a line it holds drops that line. Its next read of that address misses, goes to the bus and returns the newly written value.
- R6: A bus read for a line that another cache holds Modified returns the owner's word, and the owner downgrades to Shared. The shared store takes the same word in that cycle, and a later eviction of that line by the former owner issues no write-back.
- R7: Replacing a Modified line with a line of a different address first issues a write-back (`bus_op` = 3) carrying the dirty word to the shared store, and only then the fill. An uncontended read miss with a dirty victim therefore completes three cycles after its request.
- R8: At most one controller is granted per cycle. The grant goes round-robin starting after the last granted core, so simultaneous writes to one address are serialized and all cores end with the later-granted value.
- R9: A read following a write by the same core, with no intervening write from elsewhere, returns the written value.
- R10: `core_done` is a single-cycle pulse per request, with `core_rdata` valid in that cycle. The core removes its request in the cycle `core_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | NC | Per-core request, held until done |
| core_write | input | NC | Per-core operation: 1 write, 0 read |
| core_addr | input | NC*AW | Per-core word address, core i in bits [i*AW +: AW] |
| core_wdata | input | NC*DW | Per-core write word |
| core_done | output | NC | Per-core completion pulse |
| core_rdata | output | NC*DW | Per-core result word, valid with done |
| bus_op | output | 2 | Current bus transaction: 0 idle, 1 read, 2 invalidate, 3 write-back |
| bus_owner | output | IDW | Index of the core granted this cycle |
| bus_addr | output | AW | Address of the current transaction |

## Verification
The hardest situation to reach is two cores upgrading the same Shared line in the same cycle. The loser of arbitration is invalidated while it is still waiting, and it must then take ownership without losing its own write. The bench first makes both cores read the line. It then steers the arbiter's rotation with a lone access, so the expected winner is known, and launches both writes from parallel threads on the same edge. It checks the order of invalidates seen on the bus and the final value that both cores read. A second scenario chains dirty intervention and dirty eviction, so that the shared store can only hold the right word if both write-back paths worked.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_INV  = 2'd2,
        OP_WB   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WB   = 2'd1,
        CS_MISS = 2'd2
    } ctl_st_e;

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N   = 2,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    typedef struct packed {
        logic [IDW-1:0] last;
    } arb_t;

    arb_t arb_d, arb_q;

    always_comb begin
        logic found;
        arb_d = arb_q;
        gnt   = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(arb_q.last) + k) % N;
            if (!found && req[cand]) begin
                gnt[cand]   = 1'b1;
                found       = 1'b1;
                arb_d.last  = IDW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q.last <= IDW'(N - 1);
        end else begin
            arb_q <= arb_d;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R8
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R8
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0)); // R8

endmodule

// File: rtl/mem_store.sv
module mem_store #(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter logic [7:0] SEED = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    assign rd_data = st_q.mem[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                st_q.mem[a] <= DW'(a) ^ DW'(SEED);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_write,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    output bus_op_e       bus_req_op,
    output logic [AW-1:0] bus_req_addr,
    output logic [DW-1:0] bus_req_data,
    input  logic          bus_gnt,
    input  logic          snoop_valid,
    input  bus_op_e       snoop_op,
    input  logic [AW-1:0] snoop_addr,
    input  logic [DW-1:0] snoop_fill,
    output logic          flush_hit,
    output logic [DW-1:0] flush_data
);
    localparam int LINES = 1 << IW;
    localparam int TW    = AW - IW;

    typedef struct packed {
        ctl_st_e                  st;
        line_st_e [LINES-1:0]     ls;
        logic [LINES-1:0][TW-1:0] tag;
        logic [LINES-1:0][DW-1:0] data;
        logic                     done;
        logic [DW-1:0]            rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [IW-1:0] idx, s_idx;
    logic [TW-1:0] ctag, s_tag;
    logic          hit, s_hit, stall, victim_dirty;

    assign idx   = core_addr[IW-1:0];
    assign ctag  = core_addr[AW-1:IW];
    assign s_idx = snoop_addr[IW-1:0];
    assign s_tag = snoop_addr[AW-1:IW];

    assign hit          = (c_q.ls[idx] != LN_I) && (c_q.tag[idx] == ctag);
    assign victim_dirty = (c_q.ls[idx] == LN_M) && (c_q.tag[idx] != ctag);
    assign s_hit        = snoop_valid && !bus_gnt && (c_q.ls[s_idx] != LN_I)
                          && (c_q.tag[s_idx] == s_tag);
    assign stall        = snoop_valid && !bus_gnt && (s_idx == idx);

    assign flush_hit  = s_hit && (snoop_op == OP_RD) && (c_q.ls[s_idx] == LN_M);
    assign flush_data = c_q.data[s_idx];

    assign bus_req      = ((c_q.st == CS_WB) && (c_q.ls[idx] == LN_M)) || (c_q.st == CS_MISS);
    assign bus_req_op   = (c_q.st == CS_WB) ? OP_WB : (core_write ? OP_INV : OP_RD);
    assign bus_req_addr = (c_q.st == CS_WB) ? {c_q.tag[idx], idx} : core_addr;
    assign bus_req_data = c_q.data[idx];

    assign core_done  = c_q.done;
    assign core_rdata = c_q.rdata;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;

        // snoop side: react to other controllers' transactions
        if (s_hit) begin
            if (snoop_op == OP_INV) begin
                c_d.ls[s_idx] = LN_I;
            end else if (snoop_op == OP_RD && c_q.ls[s_idx] == LN_M) begin
                c_d.ls[s_idx] = LN_S;
            end
        end

        // core side sequencer
        unique case (c_q.st)
            CS_IDLE: begin
                if (core_req && !stall) begin
                    if (hit && !core_write) begin
                        c_d.done  = 1'b1;
                        c_d.rdata = c_q.data[idx];
                    end else if (hit && core_write && c_q.ls[idx] == LN_M) begin
                        c_d.data[idx] = core_wdata;
                        c_d.done      = 1'b1;
                        c_d.rdata     = core_wdata;
                    end else if (victim_dirty) begin
                        c_d.st = CS_WB;
                    end else begin
                        c_d.st = CS_MISS;
                    end
                end
            end
            CS_WB: begin
                if (c_q.ls[idx] != LN_M) begin
                    c_d.st = CS_MISS;
                end else if (bus_gnt) begin
                    c_d.ls[idx] = LN_I;
                    c_d.st      = CS_MISS;
                end
            end
            CS_MISS: begin
                if (bus_gnt) begin
                    c_d.tag[idx] = ctag;
                    c_d.done     = 1'b1;
                    c_d.st       = CS_IDLE;
                    if (core_write) begin
                        c_d.ls[idx]   = LN_M;
                        c_d.data[idx] = core_wdata;
                        c_d.rdata     = core_wdata;
                    end else begin
                        c_d.ls[idx]   = LN_S;
                        c_d.data[idx] = snoop_fill;
                        c_d.rdata     = snoop_fill;
                    end
                end
            end
            default: c_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st    <= CS_IDLE;
            c_q.ls    <= '0;
            c_q.tag   <= '0;
            c_q.data  <= '0;
            c_q.done  <= 1'b0;
            c_q.rdata <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    AST_MISS_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == CS_MISS && bus_gnt) |=> core_done); // R3
    AST_WRITE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == CS_MISS && bus_gnt && core_write) |=> (c_q.ls[$past(idx)] == LN_M)); // R4
    AST_INV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hit && snoop_op == OP_INV) |=> (c_q.ls[$past(s_idx)] == LN_I)); // R5
    AST_OWNER_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_hit |=> (c_q.ls[$past(s_idx)] == LN_S)); // R6
    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == CS_WB && bus_gnt) |=> (c_q.st == CS_MISS && !core_done)); // R7

endmodule

// File: rtl/snoop_cluster.sv
module snoop_cluster
    import coh_pkg::*;
#(
    parameter int NC  = 2,
    parameter int AW  = 6,
    parameter int DW  = 8,
    parameter int IW  = 2,
    parameter int IDW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    core_req,
    input  logic [NC-1:0]    core_write,
    input  logic [NC*AW-1:0] core_addr,
    input  logic [NC*DW-1:0] core_wdata,
    output logic [NC-1:0]    core_done,
    output logic [NC*DW-1:0] core_rdata,
    output logic [1:0]       bus_op,
    output logic [IDW-1:0]   bus_owner,
    output logic [AW-1:0]    bus_addr
);
    logic [NC-1:0] req, gnt, flush_vec;
    bus_op_e       req_op     [NC];
    logic [AW-1:0] req_addr   [NC];
    logic [DW-1:0] req_data   [NC];
    logic [DW-1:0] flush_word [NC];

    logic          bus_valid, flush_any;
    bus_op_e       b_op;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_data, owner_data, mem_rd, fill;
    logic          mem_we;
    logic [DW-1:0] mem_wd;

    rr_arbiter #(.N(NC), .IDW(IDW)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    // bus multiplexer: the granted controller drives the shared bus
    always_comb begin
        b_op      = OP_NONE;
        b_addr    = '0;
        b_data    = '0;
        bus_owner = '0;
        for (int i = 0; i < NC; i++) begin
            if (gnt[i]) begin
                b_op      = req_op[i];
                b_addr    = req_addr[i];
                b_data    = req_data[i];
                bus_owner = IDW'(i);
            end
        end
    end

    always_comb begin
        owner_data = '0;
        for (int i = 0; i < NC; i++) begin
            if (flush_vec[i]) begin
                owner_data = owner_data | flush_word[i];
            end
        end
    end

    assign bus_valid = |gnt;
    assign flush_any = |flush_vec;
    assign fill      = flush_any ? owner_data : mem_rd;
    assign mem_we    = (b_op == OP_WB) || (b_op == OP_RD && flush_any);
    assign mem_wd    = (b_op == OP_WB) ? b_data : owner_data;
    assign bus_op    = b_op;
    assign bus_addr  = b_addr;

    mem_store #(.AW(AW), .DW(DW), .SEED(8'h5A)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (b_addr),
        .wr_data (mem_wd),
        .rd_addr (b_addr),
        .rd_data (mem_rd)
    );

    generate
        for (genvar g = 0; g < NC; g++) begin : g_core
            coh_ctrl #(.AW(AW), .DW(DW), .IW(IW)) i_ctrl (
                .clk          (clk),
                .rst_n        (rst_n),
                .core_req     (core_req[g]),
                .core_write   (core_write[g]),
                .core_addr    (core_addr[g*AW +: AW]),
                .core_wdata   (core_wdata[g*DW +: DW]),
                .core_done    (core_done[g]),
                .core_rdata   (core_rdata[g*DW +: DW]),
                .bus_req      (req[g]),
                .bus_req_op   (req_op[g]),
                .bus_req_addr (req_addr[g]),
                .bus_req_data (req_data[g]),
                .bus_gnt      (gnt[g]),
                .snoop_valid  (bus_valid),
                .snoop_op     (b_op),
                .snoop_addr   (b_addr),
                .snoop_fill   (fill),
                .flush_hit    (flush_vec[g]),
                .flush_data   (flush_word[g])
            );
        end
    endgenerate

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_vec)); // R6
    AST_WB_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (b_op == OP_WB) |-> !flush_any); // R7
    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (b_op == OP_NONE)); // R1

endmodule

// File: tb/test_snoop_cluster.sv
module test_snoop_cluster;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int AW = 6;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    core_req = '0;
    logic [NC-1:0]    core_write = '0;
    logic [NC*AW-1:0] core_addr = '0;
    logic [NC*DW-1:0] core_wdata = '0;
    logic [NC-1:0]    core_done;
    logic [NC*DW-1:0] core_rdata;
    logic [1:0]       bus_op;
    logic [0:0]       bus_owner;
    logic [AW-1:0]    bus_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int cnt_rd = 0, cnt_inv = 0, cnt_wb = 0;
    int inv_log[$];
    logic [DW-1:0] exp_q0[$];
    logic [DW-1:0] exp_q1[$];

    snoop_cluster #(.NC(NC), .AW(AW), .DW(DW), .IW(2)) i_snoop_cluster (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (core_req),
        .core_write (core_write),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .core_done  (core_done),
        .core_rdata (core_rdata),
        .bus_op     (bus_op),
        .bus_owner  (bus_owner),
        .bus_addr   (bus_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] memv(input int a);
        return DW'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: bus statistics and scoreboard comparison
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            case (bus_op)
                2'd1: cnt_rd++;
                2'd2: begin cnt_inv++; inv_log.push_back(int'(bus_owner)); end
                2'd3: cnt_wb++;
                default: ;
            endcase
            for (int c = 0; c < NC; c++) begin
                if (core_done[c]) begin
                    logic [DW-1:0] e;
                    logic [DW-1:0] a;
                    a = core_rdata[c*DW +: DW];
                    if (c == 0) e = (exp_q0.size() > 0) ? exp_q0.pop_front() : 'x;
                    else        e = (exp_q1.size() > 0) ? exp_q1.pop_front() : 'x;
                    chk(a === e, "R9 R10 scoreboard data", int'(a), int'(e));
                end
            end
        end
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // driver: pushes the expected word, drives one request, returns its latency
    task automatic access(input int c, input bit we, input int a, input logic [DW-1:0] d,
                          input logic [DW-1:0] exp, output int lat);
        if (c == 0) exp_q0.push_back(exp); else exp_q1.push_back(exp);
        core_write[c]            = we;
        core_addr[c*AW +: AW]    = AW'(a);
        core_wdata[c*DW +: DW]   = d;
        core_req[c]              = 1'b1;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (core_done[c]) break;
        end
        core_req[c] = 1'b0;
    endtask

    task automatic run(input int c, input bit we, input int a, input logic [DW-1:0] d,
                       input logic [DW-1:0] exp, input int exp_lat,
                       input int d_rd, input int d_inv, input int d_wb, input string req);
        int lat, r0, i0, w0;
        r0 = cnt_rd; i0 = cnt_inv; w0 = cnt_wb;
        access(c, we, a, d, exp, lat);
        chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        chk((cnt_rd - r0) == d_rd && (cnt_inv - i0) == d_inv && (cnt_wb - w0) == d_wb,
            {req, " bus ops rd/inv/wb"}, (cnt_rd - r0) * 100 + (cnt_inv - i0) * 10 + (cnt_wb - w0),
            d_rd * 100 + d_inv * 10 + d_wb);
    endtask

    initial begin
        int la, lb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(core_done == '0, "R1 done low", int'(core_done), 0);
        chk(bus_op == 2'd0, "R1 bus idle", int'(bus_op), 0);

        // R1/R3: first read misses and returns store value
        run(0, 0, 4, 8'h00, memv(4), 2, 1, 0, 0, "R1 R3 cold read miss");
        // R2: read hit
        run(0, 0, 4, 8'h00, memv(4), 1, 0, 0, 0, "R2 read hit");
        // R10: done is a single pulse
        @(negedge clk);
        chk(core_done == '0, "R10 done single pulse", int'(core_done), 0);
        // R4: upgrade Shared -> Modified, then R9 read back
        run(0, 1, 4, 8'h33, 8'h33, 2, 0, 1, 0, "R4 upgrade invalidate");
        run(0, 0, 4, 8'h00, 8'h33, 1, 0, 0, 0, "R9 read after write");
        run(0, 1, 4, 8'h34, 8'h34, 1, 0, 0, 0, "R4 write hit modified");
        // R6: intervention by dirty owner
        run(1, 0, 4, 8'h00, 8'h34, 2, 1, 0, 0, "R6 owner supplies data");
        run(0, 1, 8, 8'h44, 8'h44, 2, 0, 1, 0, "R6 downgraded victim no writeback");
        run(1, 1, 12, 8'h55, 8'h55, 2, 0, 1, 0, "R6 shared victim replace");
        // R6 store updated by intervention; R7 dirty eviction of addr 8
        run(0, 0, 4, 8'h00, 8'h34, 3, 1, 0, 1, "R6 R7 store holds flushed word");
        run(1, 0, 8, 8'h00, 8'h44, 3, 1, 0, 1, "R7 writeback reached store");
        run(0, 0, 12, 8'h00, 8'h55, 2, 1, 0, 0, "R7 second eviction data");
        // R5: remote invalidate drops copy
        run(1, 0, 17, 8'h00, memv(17), 2, 1, 0, 0, "R5 prime reader");
        run(0, 0, 17, 8'h00, memv(17), 2, 1, 0, 0, "R5 prime writer");
        run(0, 1, 17, 8'h66, 8'h66, 2, 0, 1, 0, "R5 remote write");
        run(1, 0, 17, 8'h00, 8'h66, 2, 1, 0, 0, "R5 invalidated reader misses");

        // R8: simultaneous upgrades, last grant was core 1 -> core 0 wins
        run(0, 0, 18, 8'h00, memv(18), 2, 1, 0, 0, "R8 share c0");
        run(1, 0, 18, 8'h00, memv(18), 2, 1, 0, 0, "R8 share c1");
        inv_log.delete();
        fork
            access(0, 1, 18, 8'h70, 8'h70, la);
            access(1, 1, 18, 8'h71, 8'h71, lb);
        join
        chk(inv_log.size() == 2 && inv_log[0] == 0 && inv_log[1] == 1, "R8 grant order c0 first",
            (inv_log.size() == 2) ? inv_log[0] * 10 + inv_log[1] : -1, 1);
        chk(la == 2 && lb == 3, "R8 serialized latencies", la * 10 + lb, 23);
        run(0, 0, 18, 8'h00, 8'h71, 2, 1, 0, 0, "R8 c0 sees final value");
        run(1, 0, 18, 8'h00, 8'h71, 1, 0, 0, 0, "R8 c1 sees final value");

        // R8: rotation, last grant core 0 -> core 1 wins
        run(1, 0, 19, 8'h00, memv(19), 2, 1, 0, 0, "R8 share c1 second");
        run(0, 0, 19, 8'h00, memv(19), 2, 1, 0, 0, "R8 share c0 second");
        inv_log.delete();
        fork
            access(0, 1, 19, 8'h80, 8'h80, la);
            access(1, 1, 19, 8'h81, 8'h81, lb);
        join
        chk(inv_log.size() == 2 && inv_log[0] == 1 && inv_log[1] == 0, "R8 rotated order c1 first",
            (inv_log.size() == 2) ? inv_log[0] * 10 + inv_log[1] : -1, 10);
        run(1, 0, 19, 8'h00, 8'h80, 2, 1, 0, 0, "R8 c1 sees later write");
        run(0, 0, 19, 8'h00, 8'h80, 1, 0, 0, 0, "R8 c0 keeps its write");

        @(negedge clk);
        chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R10 every request completed",
            exp_q0.size() + exp_q1.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule